// File: doc/BRIEF.md
# Multiplexed Charge-Converter Scan Sequencer

This block lets one 12-bit analog-to-digital converter serve a bank of 48 charge-integrating channels. When a scan trigger arrives while the block is idle, it walks through the channels from index 0 upward. Each channel gets a slot of fixed length. First the analog multiplexer address is held for a settling interval, so the multiplexer and amplifiers can settle. Then the block issues a one-cycle start pulse to the converter and waits for the whole conversion interval. At the end of the slot the sampled code is sent on the output stream, tagged with the channel index and an error flag.

The settling and conversion intervals are parameters given in clock cycles. At 125 MHz the defaults are 1000 and 1500 cycles, which give 8 µs and 12 µs, so a full scan of 48 slots takes 960 µs. The slot length never changes, so the scan time is always the channel count times the sum of the two intervals. It does not depend on when the converter answers. A board with 96 channels places two instances side by side, each with its own converter.

The block reports `busy_o` for the whole scan. `done_o` marks the cycle that carries the final result. A converter that does not answer within its window does not stall the scan: that channel is flagged and the next slot starts on time.

Top module: `chq_scan_seq`

## Requirements
- R1: While `rst_i` is high and in the first cycle after it falls, `busy_o`, `done_o`, `res_valid_o` and `adc_start_o` are low and `mux_addr_o` is 0.
- R2: If `trig_i` is high at a clock edge while the block is idle, then in the next cycle `busy_o` is high and `mux_addr_o` is 0. That cycle is cycle 0 of the slot for channel 0.
- R3: Each channel occupies a slot of SETTLE_TICKS+CONV_TICKS cycles, and `mux_addr_o` equals the channel index for the whole slot. `adc_start_o` is high for exactly one cycle per slot, at slot cycle SETTLE_TICKS (counting from 0).
- R4: The conversion window is the `adc_start_o` cycle plus the CONV_TICKS-1 cycles after it. The reported code is the value of `adc_data_i` in the first window cycle in which `adc_ready_i` is high. Any later ready pulse in the same window is ignored.
- R5: `res_valid_o` is high for one cycle, in the first cycle after each conversion window ends. Results come in ascending channel order 0..NUM_CH-1, with `res_chan_o` giving the channel index. Every scan produces exactly NUM_CH results.
- R6: If `adc_ready_i` is never high inside a channel's window, that result has `res_err_o`=1 and `res_data_o`=0, and the next slot starts with no added delay. If ready is seen, `res_err_o`=0.
- R7: `done_o` is high for one cycle, the same cycle as the last result. `busy_o` stays high from the cycle after the trigger through that cycle, which is NUM_CH*(SETTLE_TICKS+CONV_TICKS)+1 cycles, and then goes low.
- R8: A trigger that arrives while `busy_o` is high, including in the `done_o` cycle, is ignored. It does not restart or shift the scan, and it does not start a new one.
- R9: A high `adc_ready_i` outside a conversion window (during settling or while idle) has no effect on any result.
- R10: A trigger in the first idle cycle after `busy_o` falls starts a new scan with the timing given in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Scan trigger, acted on only while idle |
| mux_addr_o | output | 6 | Analog multiplexer channel address |
| adc_start_o | output | 1 | One-cycle converter start pulse |
| adc_data_i | input | 12 | Converter output code |
| adc_ready_i | input | 1 | Converter result-ready strobe |
| res_valid_o | output | 1 | Result stream valid |
| res_data_o | output | 12 | Result code, 0 on error |
| res_chan_o | output | 6 | Channel index of the result |
| res_err_o | output | 1 | No ready seen within the conversion window |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Last result of the scan is on the stream |

## Verification
On every cycle the assertions check these local properties:
- a start pulse never lasts two cycles;
- the multiplexer address holds steady through conversion;
- results appear only while busy;
- an error result carries a zero code;
- `done_o` coincides with the final channel's result;
- busy falls only after `done_o`;
- the first captured code stays unchanged for the rest of its window.

Absolute slot timing, ascending channel order, the result count, and the choice between first ready and later or out-of-window ready pulses can only be shown by the bench's scenarios. The bench compares them against a cycle-indexed model under normal, varied-latency, timeout, spurious-ready, retrigger and back-to-back patterns.

// File: rtl/chq_scan_pkg.sv
`timescale 1ns/1ps
package chq_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2,
        ST_FINISH = 2'd3
    } scan_state_e;

    // bits needed to hold any value up to max(a, b)
    function automatic int cnt_bits(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 1) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/chq_slot_timer.sv
`timescale 1ns/1ps
module chq_slot_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             first_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign first_o  = (cnt_q == '0);
    assign expire_o = (cnt_q == lim_i - CNT_W'(1));

    // R3: the interval count never runs past the active interval length
    a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < lim_i);

endmodule

// File: rtl/chq_result_capture.sv
`timescale 1ns/1ps
module chq_result_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              open_i,
    input  logic              win_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ok_o,
    output logic [DATA_W-1:0] data_o
);
    logic              got_q;
    logic [DATA_W-1:0] cap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            got_q <= 1'b0;
            cap_q <= '0;
        end else if (open_i) begin
            got_q <= ready_i;
            cap_q <= ready_i ? data_i : '0;
        end else if (win_i && ready_i && !got_q) begin
            got_q <= 1'b1;
            cap_q <= data_i;
        end
    end

    always_comb begin
        if (open_i) begin
            ok_o   = ready_i;
            data_o = ready_i ? data_i : '0;
        end else if (got_q) begin
            ok_o   = 1'b1;
            data_o = cap_q;
        end else if (win_i && ready_i) begin
            ok_o   = 1'b1;
            data_o = data_i;
        end else begin
            ok_o   = 1'b0;
            data_o = '0;
        end
    end

    // R4: once a code is held, later strobes in the window leave it unchanged
    a_r4_first_kept: assert property (@(posedge clk_i) disable iff (rst_i)
        (got_q && win_i && !open_i) |=> (open_i || $stable(cap_q)));

endmodule

// File: rtl/chq_scan_seq.sv
`timescale 1ns/1ps
module chq_scan_seq #(
    parameter int NUM_CH       = 48,
    parameter int DATA_W       = 12,
    parameter int SETTLE_TICKS = 1000,
    parameter int CONV_TICKS   = 1500
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      trig_i,
    output logic [$clog2(NUM_CH)-1:0] mux_addr_o,
    output logic                      adc_start_o,
    input  logic [DATA_W-1:0]         adc_data_i,
    input  logic                      adc_ready_i,
    output logic                      res_valid_o,
    output logic [DATA_W-1:0]         res_data_o,
    output logic [$clog2(NUM_CH)-1:0] res_chan_o,
    output logic                      res_err_o,
    output logic                      busy_o,
    output logic                      done_o
);
    import chq_scan_pkg::*;

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int CNT_W = cnt_bits(SETTLE_TICKS, CONV_TICKS);
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_TICKS);
    localparam logic [CNT_W-1:0] CONV_LIM   = CNT_W'(CONV_TICKS);
    localparam logic [CH_W-1:0]  LAST_CH    = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic              err;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] code;
    } slot_res_t;

    scan_state_e       state_q, state_d;
    logic [CH_W-1:0]   chan_q, chan_d;
    logic              emit;
    logic              tmr_clr, tmr_first, tmr_expire;
    logic [CNT_W-1:0]  tmr_lim;
    logic              cap_ok;
    logic [DATA_W-1:0] cap_data;
    logic              in_conv;
    logic              valid_q;
    slot_res_t         res_q;

    // ---------------- sequencing ----------------
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        emit    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                chan_d = '0;
                if (trig_i) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_expire) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (tmr_expire) begin
                    emit = 1'b1;
                    if (chan_q == LAST_CH) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_SETTLE;
                        chan_d  = chan_q + CH_W'(1);
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
                chan_d  = '0;
            end
            default: begin
                state_d = ST_IDLE;
                chan_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    assign tmr_lim = (state_q == ST_CONV) ? CONV_LIM : SETTLE_LIM;
    assign tmr_clr = (state_d != state_q) || (state_q == ST_IDLE);

    chq_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (tmr_clr),
        .lim_i    (tmr_lim),
        .first_o  (tmr_first),
        .expire_o (tmr_expire)
    );

    assign in_conv     = (state_q == ST_CONV);
    assign adc_start_o = in_conv && tmr_first;

    chq_result_capture #(.DATA_W(DATA_W)) u_capture (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .open_i  (adc_start_o),
        .win_i   (in_conv),
        .ready_i (adc_ready_i),
        .data_i  (adc_data_i),
        .ok_o    (cap_ok),
        .data_o  (cap_data)
    );

    // ---------------- result stream ----------------
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= emit;
            if (emit) begin
                res_q.err  <= !cap_ok;
                res_q.chan <= chan_q;
                res_q.code <= cap_data;
            end
        end
    end

    assign res_valid_o = valid_q;
    assign res_data_o  = res_q.code;
    assign res_chan_o  = res_q.chan;
    assign res_err_o   = res_q.err;
    assign mux_addr_o  = chan_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FINISH);

    // ---------------- assertions ----------------
    a_r2_trig_starts: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && trig_i) |=> (busy_o && mux_addr_o == '0));

    a_r3_start_single: assert property (@(posedge clk_i) disable iff (rst_i)
        adc_start_o |=> !adc_start_o);

    a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_conv && busy_o) |-> $stable(mux_addr_o));

    a_r5_valid_in_scan: assert property (@(posedge clk_i) disable iff (rst_i)
        res_valid_o |-> busy_o);

    a_r6_err_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_o && res_err_o) |-> (res_data_o == '0));

    a_r7_done_last: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (res_valid_o && res_chan_o == LAST_CH));

    a_r8_busy_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> $past(done_o));

endmodule

// File: tb/test_chq_scan_seq.sv
`timescale 1ns/1ps
module test_chq_scan_seq;
    localparam int N  = 48;
    localparam int S  = 4;
    localparam int C  = 6;
    localparam int P  = S + C;
    localparam int DW = 12;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          adc_ready = 1'b0;
    logic [CW-1:0] mux_addr;
    logic          adc_start;
    logic          res_valid;
    logic [DW-1:0] res_data;
    logic [CW-1:0] res_chan;
    logic          res_err;
    logic          busy;
    logic          done;

    always #4 clk = ~clk;

    chq_scan_seq #(
        .NUM_CH(N), .DATA_W(DW), .SETTLE_TICKS(S), .CONV_TICKS(C)
    ) i_chq_scan_seq (
        .clk_i(clk), .rst_i(rst), .trig_i(trig),
        .mux_addr_o(mux_addr), .adc_start_o(adc_start),
        .adc_data_i(adc_data), .adc_ready_i(adc_ready),
        .res_valid_o(res_valid), .res_data_o(res_data),
        .res_chan_o(res_chan), .res_err_o(res_err),
        .busy_o(busy), .done_o(done)
    );

    int  tests = 0;
    int  fails = 0;
    bit  finished = 0;
    int  lat [N];
    bit  spur = 0;
    bit  dbl = 0;
    int  scan_id = 0;
    bit  chk_en = 0;
    int  res_cnt = 0;
    int  err_cnt = 0;
    bit  run = 0;
    int  t = 0;

    function automatic int code_of(int ch, int sid);
        return (ch * 37 + sid * 101 + 5) % 4096;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model: cycle index within the scan
    always @(posedge clk) begin
        if (rst) begin
            run = 0;
            t   = 0;
        end else if (!run) begin
            if (trig) begin
                run = 1;
                t   = 0;
            end
        end else if (t == N * P) begin
            run = 0;
        end else begin
            t = t + 1;
        end
    end

    // compare outputs and drive the converter model
    always @(negedge clk) begin
        int e_mux, ch, ph, off, ed, ee;
        bit e_start, e_valid, e_done, r;
        logic [DW-1:0] d;
        if (chk_en) begin
            e_mux   = run ? ((t < N * P) ? t / P : N - 1) : 0;
            e_start = run && (t < N * P) && (t % P == S);
            e_valid = run && (t > 0) && (t % P == 0);
            e_done  = run && (t == N * P);
            check(busy == run, "R7", "busy", int'(busy), int'(run));
            check(int'(mux_addr) == e_mux, "R3", "mux_addr", int'(mux_addr), e_mux);
            check(adc_start == e_start, "R3", "adc_start", int'(adc_start), int'(e_start));
            check(res_valid == e_valid, "R5", "res_valid", int'(res_valid), int'(e_valid));
            check(done == e_done, "R7", "done", int'(done), int'(e_done));
            if (e_valid) begin
                ch = t / P - 1;
                ed = (lat[ch] < C) ? code_of(ch, scan_id) : 0;
                ee = (lat[ch] < C) ? 0 : 1;
                check(int'(res_chan) == ch, "R5", "res_chan", int'(res_chan), ch);
                check(int'(res_data) == ed, "R4 R9", "res_data", int'(res_data), ed);
                check(int'(res_err) == ee, "R6", "res_err", int'(res_err), ee);
                res_cnt++;
                if (res_err) err_cnt++;
            end
        end
        r = 0;
        d = 12'hABC;
        if (run && t < N * P) begin
            ch  = t / P;
            ph  = t % P;
            off = ph - S;
            if (off >= 0 && off == lat[ch]) begin
                r = 1;
                d = DW'(code_of(ch, scan_id));
            end else if (dbl && off >= 0 && off == lat[ch] + 1) begin
                r = 1;
            end else if (spur && ph == 1) begin
                r = 1;
            end
        end else if (spur) begin
            r = 1;
        end
        adc_ready = r;
        adc_data  = d;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic do_scan(bit retrig, int exp_err);
        res_cnt = 0;
        err_cnt = 0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        // R2: first cycle after the trigger edge
        check(busy === 1'b1 && mux_addr === '0, "R2", "busy/mux after trigger",
              int'(busy), 1);
        if (retrig) begin
            while (!(run && t == 3 * P + 2)) @(negedge clk);
            trig = 1'b1;          // R8: mid-scan trigger
            @(negedge clk);
            trig = 1'b0;
            while (!(run && t == N * P)) @(negedge clk);
            trig = 1'b1;          // R8: trigger in the done cycle
            @(negedge clk);
            trig = 1'b0;
            repeat (3) @(negedge clk);
            check(busy == 1'b0, "R8", "no restart after ignored trigger", int'(busy), 0);
        end else begin
            while (run) @(negedge clk);
        end
        check(res_cnt == N, "R5", "results per scan", res_cnt, N);
        check(err_cnt == exp_err, "R6", "error results", err_cnt, exp_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R7", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) lat[i] = 2;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(!busy && !done && !res_valid && !adc_start && mux_addr == '0,
              "R1", "idle outputs in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !res_valid && !adc_start && mux_addr == '0,
              "R1", "idle outputs after reset", int'(busy), 0);
        chk_en = 1;
        repeat (3) @(negedge clk);

        // scan 1: uniform latency
        scan_id = 1;
        do_scan(0, 0);
        repeat (5) @(negedge clk);

        // scan 2: latencies across the window, some timeouts (R6)
        scan_id = 2;
        for (int i = 0; i < N; i++) lat[i] = i % C;
        lat[7] = C; lat[20] = C + 3; lat[47] = 100;
        do_scan(0, 3);
        repeat (5) @(negedge clk);

        // scan 3: spurious out-of-window and repeated strobes (R4, R9), retriggers (R8)
        scan_id = 3;
        spur = 1;
        dbl  = 1;
        for (int i = 0; i < N; i++) lat[i] = (i * 5) % C;
        lat[0] = C + 1;
        do_scan(1, 1);
        spur = 0;
        dbl  = 0;

        // scan 4: R10 back-to-back trigger in first idle cycle
        scan_id = 4;
        for (int i = 0; i < N; i++) lat[i] = C - 1;
        check(busy == 1'b0, "R10", "idle before back-to-back", int'(busy), 0);
        do_scan(0, 0);
        scan_id = 5;
        check(busy == 1'b0, "R10", "idle between scans", int'(busy), 0);
        do_scan(0, 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule